// File: doc/BRIEF.md
# 4x4 Key Matrix Scanner with Press Confirmation

This block scans a sixteen-key matrix of four rows and four columns. It drives one row high at a time, in rising row order, and reads the four column lines back through a two-flop synchronizer. When a column reads high, the block records where the key sits. It keeps the same row driven for a debounce interval and then looks at that one column again. If the key is still down, the block reports it as a 4-bit code (row times four plus column) together with a single-cycle strobe. If the key is gone, the detection is dropped and scanning moves on to the next row.

Once a key has been reported, the block drives every row high. It waits until all columns have read low for one full debounce interval in a row, and only then resumes scanning from row 0. A key that is held down is therefore reported once. Both the debounce interval and the time spent on each row are parameters counted in clock cycles. The default debounce is about 10 ms at a 100 MHz clock.

Top module: `kp_scanner`

## Requirements
- R1: While reset is high and on the first cycle after it, row_o is 4'b0001, key_valid_o is 0 and key_o is 0.
- R2: While scanning, exactly one bit of row_o is high (bit i drives row i). Each row stays driven for DWELL_CYC cycles, and the next row is the previous one rotated left by one (0,1,2,3,0...).
- R3: col_i bit j is column j, and a pressed key reads 1 on its column while its row is driven. The reported code key_o equals row*4 + column.
- R4: If several columns read 1 on the same row, the lowest-numbered column is reported.
- R5: A key is reported only if its column still reads 1 after DEBOUNCE_CYC cycles on the same row. A contact that is closed for fewer cycles than that produces no report.
- R6: key_valid_o is high for exactly one cycle per report. A press that bounces before it settles gives exactly one report.
- R7: After a report all four rows are driven high and no further report occurs. Scanning resumes only after the columns have read all-zero for DEBOUNCE_CYC consecutive cycles, so a held key, or one that is briefly released and pressed again, is reported once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| col_i | input | 4 | Column sense lines, asynchronous, high when a key on the driven row is closed |
| row_o | output | 4 | Row drive lines, active high |
| key_o | output | 4 | Code of the last reported key, row*4 + column |
| key_valid_o | output | 1 | One-cycle strobe marking a new report on key_o |

## Verification
A change on col_i reaches the scanner two cycles later, after the synchronizer. A report then arrives after up to one full lap of the rows, plus one row dwell, plus DEBOUNCE_CYC cycles. With the small configuration the bench uses, that is bounded by 5*DWELL_CYC + DEBOUNCE_CYC + 10 cycles. The bench therefore counts strobes over fixed windows of at least that length, not at a single cycle. A windowed count catches both a missing report and a doubled one. Release is due DEBOUNCE_CYC + 2 cycles after the columns clear, and each settling wait is sized to that bound before the counts are compared. Row stepping is checked at every falling edge against the rotate rule and the dwell length.

// File: rtl/kp_pkg.sv
`timescale 1ns/1ps
package kp_pkg;
    localparam int ROWS  = 4;
    localparam int COLS  = 4;
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS);
    localparam int KEY_W = ROW_W + COL_W;

    typedef enum logic [1:0] {
        ST_SCAN    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_RELEASE = 2'd2
    } kp_state_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } kp_pos_t;

    function automatic logic [ROWS-1:0] row_select(input logic [ROW_W-1:0] idx);
        logic [ROWS-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    function automatic logic [ROW_W-1:0] row_index(input logic [ROWS-1:0] v);
        logic [ROW_W-1:0] idx;
        idx = '0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (v[i]) idx = ROW_W'(i);
        end
        return idx;
    endfunction

    function automatic logic [KEY_W-1:0] key_code(input kp_pos_t p);
        return {p.row, p.col};
    endfunction
endpackage

// File: rtl/kp_sync.sv
`timescale 1ns/1ps
module kp_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/kp_col_pick.sv
`timescale 1ns/1ps
module kp_col_pick
    import kp_pkg::*;
(
    input  logic [COLS-1:0]  cols,
    output logic             found,
    output logic [COL_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int j = COLS - 1; j >= 0; j--) begin
            if (cols[j]) idx = COL_W'(j);
        end
        found = |cols;
    end
endmodule

// File: rtl/kp_timer.sv
`timescale 1ns/1ps
module kp_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] last,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (cnt != last) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == last);
endmodule

// File: rtl/kp_scanner.sv
`timescale 1ns/1ps
module kp_scanner
    import kp_pkg::*;
#(
    parameter int DEBOUNCE_CYC = 1_000_000,
    parameter int DWELL_CYC    = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [COLS-1:0]  col_i,
    output logic [ROWS-1:0]  row_o,
    output logic [KEY_W-1:0] key_o,
    output logic             key_valid_o
);
    localparam int DEB_W   = $clog2(DEBOUNCE_CYC + 1);
    localparam int DWELL_W = $clog2(DWELL_CYC + 1);

    kp_state_e        st;
    logic [ROW_W-1:0] row_idx;
    kp_pos_t          cap;
    logic [COLS-1:0]  col_s;
    logic             pick_found;
    logic [COL_W-1:0] pick_idx;
    logic             dwell_clr, dwell_done;
    logic             deb_clr, deb_done;

    kp_sync #(.W(COLS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(col_i), .q(col_s)
    );

    kp_col_pick u_pick (
        .cols(col_s), .found(pick_found), .idx(pick_idx)
    );

    kp_timer #(.W(DWELL_W)) u_dwell (
        .clk(clk), .rst(rst), .clr(dwell_clr),
        .last(DWELL_W'(DWELL_CYC - 1)), .done(dwell_done)
    );

    kp_timer #(.W(DEB_W)) u_deb (
        .clk(clk), .rst(rst), .clr(deb_clr),
        .last(DEB_W'(DEBOUNCE_CYC - 1)), .done(deb_done)
    );

    always_comb begin
        dwell_clr = (st != ST_SCAN) || dwell_done;
        unique case (st)
            ST_SCAN:    deb_clr = 1'b1;
            ST_CONFIRM: deb_clr = deb_done;
            ST_RELEASE: deb_clr = (|col_s) || deb_done;
            default:    deb_clr = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_SCAN;
            row_idx     <= '0;
            cap         <= '0;
            key_o       <= '0;
            key_valid_o <= 1'b0;
        end else begin
            key_valid_o <= 1'b0;
            unique case (st)
                ST_SCAN: begin
                    if (dwell_done) begin
                        if (pick_found) begin
                            cap.row <= row_idx;
                            cap.col <= pick_idx;
                            st      <= ST_CONFIRM;
                        end else begin
                            row_idx <= row_idx + 1'b1;
                        end
                    end
                end
                ST_CONFIRM: begin
                    if (deb_done) begin
                        if (col_s[cap.col]) begin
                            key_o       <= key_code(cap);
                            key_valid_o <= 1'b1;
                            st          <= ST_RELEASE;
                        end else begin
                            row_idx <= row_idx + 1'b1;
                            st      <= ST_SCAN;
                        end
                    end
                end
                ST_RELEASE: begin
                    if (!(|col_s) && deb_done) begin
                        row_idx <= '0;
                        st      <= ST_SCAN;
                    end
                end
                default: st <= ST_SCAN;
            endcase
        end
    end

    assign row_o = (st == ST_RELEASE) ? {ROWS{1'b1}} : row_select(row_idx);
endmodule

// File: rtl/kp_scanner_chk.sv
`timescale 1ns/1ps
module kp_scanner_chk
    import kp_pkg::*;
#(
    parameter int DEBOUNCE_CYC = 1_000_000
) (
    input logic             clk,
    input logic             rst,
    input logic [ROWS-1:0]  row_o,
    input logic [KEY_W-1:0] key_o,
    input logic             key_valid_o,
    input logic [COLS-1:0]  col_s
);
    logic [ROWS-1:0] row_q;
    logic [31:0]     hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q    <= '0;
            hold_cnt <= '0;
        end else begin
            row_q <= row_o;
            if (row_o != row_q) hold_cnt <= '0;
            else if (hold_cnt != 32'hFFFF_FFFF) hold_cnt <= hold_cnt + 1;
        end
    end

    p_row_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        (row_o != {ROWS{1'b1}}) |-> $onehot(row_o));

    p_row_step_r2: assert property (@(posedge clk) disable iff (rst)
        ($onehot(row_o) && $onehot($past(row_o)) && row_o != $past(row_o))
        |-> row_o == {$past(row_o[ROWS-2:0]), $past(row_o[ROWS-1])});

    p_code_row_r3: assert property (@(posedge clk) disable iff (rst)
        key_valid_o |-> key_o[KEY_W-1:COL_W] == row_index($past(row_o)));

    p_held_long_r5: assert property (@(posedge clk) disable iff (rst)
        key_valid_o |-> hold_cnt >= 32'(DEBOUNCE_CYC));

    p_still_down_r5: assert property (@(posedge clk) disable iff (rst)
        key_valid_o |-> (($past(col_s) >> key_o[COL_W-1:0]) & COLS'(1)) != '0);

    p_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        key_valid_o |=> !key_valid_o);

    p_quiet_release_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(row_o) == {ROWS{1'b1}}) |-> !key_valid_o);
endmodule

bind kp_scanner kp_scanner_chk #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_chk (
    .clk(clk), .rst(rst), .row_o(row_o), .key_o(key_o),
    .key_valid_o(key_valid_o), .col_s(col_s)
);

// File: tb/sim_kp_scanner.sv
`timescale 1ns/1ps
module sim_kp_scanner;
    localparam int DEB   = 20;
    localparam int DWELL = 4;
    localparam int LAT   = 5 * DWELL + DEB + 10;
    localparam int HOLD  = LAT + 3 * DEB;
    localparam int SETTLE = 2 * DEB + 5 * DWELL + 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] col_i;
    logic [3:0] row_o;
    logic [3:0] key_o;
    logic       key_valid_o;
    logic [15:0] pressed = '0;

    int checks = 0;
    int errors = 0;
    int nval = 0;
    int last_key = -1;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    kp_scanner #(.DEBOUNCE_CYC(DEB), .DWELL_CYC(DWELL)) u0 (
        .clk(clk), .rst(rst), .col_i(col_i), .row_o(row_o),
        .key_o(key_o), .key_valid_o(key_valid_o)
    );

    always_comb begin
        for (int c = 0; c < 4; c++) begin
            col_i[c] = 1'b0;
            for (int r = 0; r < 4; r++)
                col_i[c] = col_i[c] | (row_o[r] & pressed[r*4+c]);
        end
    end

    always @(negedge clk) begin
        if (!rst && key_valid_o) begin
            nval++;
            last_key = int'(key_o);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic press_once(input logic [15:0] keys, input int exp_code,
                              input string req);
        nval = 0;
        last_key = -1;
        pressed = keys;
        wait_cyc(HOLD);
        check(nval == 1, "R6", "reports while held", nval, 1);
        check(last_key == exp_code, req, "key code", last_key, exp_code);
        pressed = '0;
        wait_cyc(SETTLE);
        check(nval == 1, "R7", "reports after release", nval, 1);
    endtask

    initial begin
        col_i = '0;
        repeat (3) @(negedge clk);
        check(row_o == 4'b0001, "R1", "row in reset", row_o, 1);
        check(key_valid_o == 1'b0, "R1", "valid in reset", key_valid_o, 0);
        check(key_o == 4'd0, "R1", "key in reset", key_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(row_o == 4'b0001 && !key_valid_o && key_o == 0, "R1",
              "first cycle after reset", row_o, 1);

        begin
            logic [3:0] prev;
            int run;
            bit first;
            prev = row_o;
            run = 1;
            first = 1'b1;
            for (int i = 0; i < 8 * DWELL * 4; i++) begin
                @(negedge clk);
                if (row_o != prev) begin
                    check(row_o == {prev[2:0], prev[3]}, "R2", "row step",
                          row_o, {prev[2:0], prev[3]});
                    if (!first) check(run == DWELL, "R2", "row dwell", run, DWELL);
                    first = 1'b0;
                    run = 1;
                    prev = row_o;
                end else begin
                    run++;
                end
                check($countones(row_o) == 1, "R2", "one row driven", row_o, 1);
            end
        end

        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                press_once(16'(1) << (r * 4 + c), r * 4 + c, "R3");

        for (int r = 0; r < 4; r++)
            for (int a = 0; a < 4; a++)
                for (int b = a + 1; b < 4; b++)
                    press_once((16'(1) << (r * 4 + a)) | (16'(1) << (r * 4 + b)),
                               r * 4 + a, "R4");

        nval = 0;
        for (int i = 0; i < 16; i++) begin
            wait_cyc(i);
            pressed = 16'(1) << ((i * 5) % 16);
            wait_cyc(5);
            pressed = '0;
            wait_cyc(DEB + 3 * DWELL + 8);
        end
        check(nval == 0, "R5", "short contacts reported", nval, 0);

        nval = 0;
        last_key = -1;
        for (int t = 0; t < 10; t++) begin
            pressed = (t % 2 == 0) ? 16'(1) << 9 : 16'h0;
            wait_cyc(3);
        end
        pressed = 16'(1) << 9;
        wait_cyc(HOLD);
        check(nval == 1, "R6", "bouncing press reports", nval, 1);
        check(last_key == 9, "R6", "bouncing press code", last_key, 9);

        pressed = '0;
        wait_cyc(DEB / 2);
        pressed = 16'(1) << 9;
        wait_cyc(HOLD);
        check(nval == 1, "R7", "brief release then re-press", nval, 1);
        pressed = '0;
        wait_cyc(SETTLE);
        press_once(16'(1) << 6, 6, "R7");

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule